// File: doc/BRIEF.md
# Soft-Reset Synchronization Sequencer for a Two-Channel Sample Path

This block sits between a software-written run/reset control bit and a stereo sample datapath. All of its delays are measured in sample periods, marked by a one-clock strobe. When software clears the control bit, both zero-detect flags go high at once. The datapath reset follows the bit only after a lag of several sample periods, and it lags the same way when the bit is set again. While the datapath reset is held, the outputs are zero.

The zero-detect flags also arm resynchronization. While both flags are high, an external sync event resets the free-running sample-phase counter and blanks the sample outputs for a fixed window. The flags go high as soon as the bit is cleared, so a sync can land before the internal reset has changed. The flags drop a short time after the internal reset is released.

Top module: `srst_sync_seq`

## Requirements
- R1: Asynchronous power-on reset (rst_n low) gives int_rst_n=0, zdet_l=zdet_r=1, phase=0, force_zero=1 and both data outputs zero.
- R2: A change of rst_bit from 1 to 0 drives zdet_l and zdet_r high on the following clock edge.
- R3: After rst_bit changes, int_rst_n takes the new value on the clock edge of the 4th fs_tick that follows the write, on both falling and rising changes, and never between ticks.
- R4: A write during a pending lag restarts the lag for the newest value. If rst_bit returns to the value int_rst_n already holds, int_rst_n does not change.
- R5: A sync_evt is accepted only while both zero-detect flags are high. An accepted sync sets phase to 0 on the next edge. A sync at any other time leaves phase and force_zero unaffected.
- R6: On each fs_tick, phase advances by one modulo PERIOD (default 8), unless a sync is accepted in the same cycle.
- R7: After an accepted sync, force_zero stays high and both data outputs stay zero until the edge of the 5th fs_tick that follows. A later accepted sync restarts the window.
- R8: Once int_rst_n is 1 with no lag pending, both zero-detect flags fall on the edge of the 2nd fs_tick that follows.
- R9: While int_rst_n is 0, force_zero is 1 and both data outputs are zero. When no force is active, dout_l/dout_r equal din_l/din_r.
- R10: A sync accepted after rst_bit is cleared but before int_rst_n falls still resets phase and starts the force window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| fs_tick | input | 1 | One-cycle sample-rate strobe |
| rst_bit | input | 1 | Register value of the control bit (0 = reset, 1 = run) |
| sync_evt | input | 1 | External sync event request |
| din_l | input | DW | Left sample in |
| din_r | input | DW | Right sample in |
| int_rst_n | output | 1 | Delayed internal datapath reset, active low |
| zdet_l | output | 1 | Left zero-detect flag |
| zdet_r | output | 1 | Right zero-detect flag |
| phase | output | PW | Sample-phase counter |
| force_zero | output | 1 | Data zero gate |
| dout_l | output | DW | Gated left sample out |
| dout_r | output | DW | Gated right sample out |

## Verification
The assertions check properties that hold on every cycle. The zero outputs while int_rst_n is low, the flags rising after a clear of the bit, and the phase step on a tick are checked this way. So are phase clearing on an accepted sync, and int_rst_n and flag edges falling only on tick edges. Only the bench scenarios can show the exact tick counts. These are the 4-tick lag, the 5-tick force window and the 2-tick flag release. The scenarios also cover a lag restart by a rewrite and a sync that lands before the internal reset asserts.

// File: rtl/srst_sync_seq.sv
module srst_sync_seq #(
  parameter int DW        = 24,
  parameter int LAG_TICKS = 3,
  parameter int FZ_TICKS  = 4,
  parameter int ZD_TICKS  = 2,
  parameter int PERIOD    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs_tick,
  input  logic          rst_bit,
  input  logic          sync_evt,
  input  logic [DW-1:0] din_l,
  input  logic [DW-1:0] din_r,
  output logic          int_rst_n,
  output logic          zdet_l,
  output logic          zdet_r,
  output logic [$clog2(PERIOD)-1:0] phase,
  output logic          force_zero,
  output logic [DW-1:0] dout_l,
  output logic [DW-1:0] dout_r
);
  localparam int PW = $clog2(PERIOD);
  localparam int CW = $clog2(LAG_TICKS + FZ_TICKS + ZD_TICKS + 2);

  logic          seen, pend, irn, zd, fz;
  logic [CW-1:0] lag_cnt, zd_cnt, fz_cnt;
  logic [PW-1:0] ph;

  wire chg     = rst_bit != seen;
  wire sync_ok = sync_evt & zd;
  wire zd_run  = irn & ~pend & seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= rst_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend    <= 1'b0;
      lag_cnt <= '0;
      irn     <= 1'b0;
    end else if (chg) begin
      pend    <= 1'b1;
      lag_cnt <= '0;
    end else if (pend && fs_tick) begin
      if (lag_cnt == CW'(LAG_TICKS)) begin
        irn  <= seen;
        pend <= 1'b0;
      end else begin
        lag_cnt <= lag_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      zd     <= 1'b1;
      zd_cnt <= '0;
    end else if (chg && !rst_bit) begin
      zd     <= 1'b1;
      zd_cnt <= '0;
    end else if (!zd_run) begin
      zd_cnt <= '0;
    end else if (zd && fs_tick) begin
      if (zd_cnt == CW'(ZD_TICKS - 1)) zd <= 1'b0;
      else                             zd_cnt <= zd_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fz     <= 1'b0;
      fz_cnt <= '0;
    end else if (sync_ok) begin
      fz     <= 1'b1;
      fz_cnt <= '0;
    end else if (fz && fs_tick) begin
      if (fz_cnt == CW'(FZ_TICKS)) fz <= 1'b0;
      else                         fz_cnt <= fz_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ph <= '0;
    else if (sync_ok) ph <= '0;
    else if (fs_tick) ph <= (ph == PW'(PERIOD - 1)) ? '0 : ph + 1'b1;

  assign int_rst_n  = irn;
  assign zdet_l     = zd;
  assign zdet_r     = zd;
  assign phase      = ph;
  assign force_zero = fz | ~irn;
  assign dout_l     = force_zero ? '0 : din_l;
  assign dout_r     = force_zero ? '0 : din_r;
endmodule

// File: rtl/srst_sync_seq_chk.sv
module srst_sync_seq_chk #(
  parameter int DW     = 24,
  parameter int PERIOD = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fs_tick,
  input logic          rst_bit,
  input logic          sync_evt,
  input logic [DW-1:0] din_l,
  input logic [DW-1:0] din_r,
  input logic          int_rst_n,
  input logic          zdet_l,
  input logic          zdet_r,
  input logic [$clog2(PERIOD)-1:0] phase,
  input logic          force_zero,
  input logic [DW-1:0] dout_l,
  input logic [DW-1:0] dout_r
);
  localparam int PW = $clog2(PERIOD);

  a_r2_clear_raises_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_bit) |=> (zdet_l && zdet_r));

  a_r3_lag_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(int_rst_n) |-> $past(fs_tick));

  a_r5_sync_clears_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_evt && zdet_l && zdet_r) |=> (phase == '0 && force_zero));

  a_r6_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_tick && !(sync_evt && zdet_l && zdet_r)) |=>
      phase == (($past(phase) == PW'(PERIOD - 1)) ? PW'(0) : PW'($past(phase) + 1'b1)));

  a_r8_flag_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zdet_l) |-> ($past(fs_tick) && int_rst_n));

  a_r9_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !int_rst_n |-> (force_zero && dout_l == '0 && dout_r == '0));
endmodule

bind srst_sync_seq srst_sync_seq_chk #(.DW(DW), .PERIOD(PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .rst_bit(rst_bit),
  .sync_evt(sync_evt), .din_l(din_l), .din_r(din_r), .int_rst_n(int_rst_n),
  .zdet_l(zdet_l), .zdet_r(zdet_r), .phase(phase), .force_zero(force_zero),
  .dout_l(dout_l), .dout_r(dout_r)
);

// File: tb/srst_sync_seq_tb.sv
module srst_sync_seq_tb;
  localparam int CLK_P = 10;
  localparam int DW    = 24;

  logic clk = 1'b0, rst_n = 1'b0, fs_tick = 1'b0, rst_bit = 1'b0, sync_evt = 1'b0;
  logic [DW-1:0] din_l = 24'h123456, din_r = 24'h0abcde;
  logic int_rst_n, zdet_l, zdet_r, force_zero;
  logic [2:0] phase;
  logic [DW-1:0] dout_l, dout_r;
  int n_chk = 0, n_bad = 0;
  logic [2:0] p;

  always #(CLK_P/2) clk = ~clk;

  srst_sync_seq u_dut (
    .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .rst_bit(rst_bit),
    .sync_evt(sync_evt), .din_l(din_l), .din_r(din_r), .int_rst_n(int_rst_n),
    .zdet_l(zdet_l), .zdet_r(zdet_r), .phase(phase), .force_zero(force_zero),
    .dout_l(dout_l), .dout_r(dout_r)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) fs_tick = 1'b1;
      @(negedge clk) fs_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic wr(input logic v);
    @(negedge clk) rst_bit = v;
    @(negedge clk);
  endtask

  task automatic sync;
    @(negedge clk) sync_evt = 1'b1;
    @(negedge clk) sync_evt = 1'b0;
  endtask

  task automatic t_por;
    repeat (2) @(negedge clk);
    chk("R1 int_rst_n", int_rst_n, 0);
    chk("R1 flags", {zdet_l, zdet_r}, 2'b11);
    chk("R1 phase", phase, 0);
    chk("R1 force_zero", force_zero, 1);
    chk("R1 dout", {dout_l, dout_r}, 0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_release;
    wr(1'b1);
    tick(3);
    chk("R3 rise not yet", int_rst_n, 0);
    chk("R9 dout held", dout_l, 0);
    tick(1);
    chk("R3 rise on 4th tick", int_rst_n, 1);
    chk("R9 dout passes", dout_l, din_l);
    tick(1);
    chk("R8 flag after 1 tick", zdet_r, 1);
    tick(1);
    chk("R8 flags after 2 ticks", {zdet_l, zdet_r}, 2'b00);
  endtask

  task automatic t_phase_and_ignored_sync;
    p = phase;
    tick(3);
    chk("R6 phase +3", phase, 3'(p + 3));
    tick(6);
    chk("R6 phase wraps", phase, 3'(p + 9));
    p = phase;
    sync();
    chk("R5 ignored sync phase", phase, p);
    chk("R5 ignored sync force", force_zero, 0);
    chk("R5 ignored sync dout", dout_r, din_r);
  endtask

  task automatic t_early_sync_and_restore;
    tick(1);
    wr(1'b0);
    chk("R2 flags up", {zdet_l, zdet_r}, 2'b11);
    chk("R10 int not yet", int_rst_n, 1);
    sync();
    chk("R10 phase cleared", phase, 0);
    chk("R10 force", force_zero, 1);
    chk("R7 dout zero", dout_l, 0);
    wr(1'b1);
    tick(4);
    chk("R4 int unchanged", int_rst_n, 1);
    chk("R7 force at 4 ticks", force_zero, 1);
    tick(1);
    chk("R7 force ends at 5th", force_zero, 0);
    chk("R7 dout restored", dout_r, din_r);
    chk("R8 flags still up", zdet_l, 1);
    tick(1);
    chk("R8 flags down", {zdet_l, zdet_r}, 2'b00);
  endtask

  task automatic t_full_cycle;
    wr(1'b0);
    tick(3);
    chk("R3 fall not yet", int_rst_n, 1);
    tick(1);
    chk("R3 fall on 4th tick", int_rst_n, 0);
    chk("R9 forced", force_zero, 1);
    chk("R9 dout zero", {dout_l, dout_r}, 0);
    tick(2);
    sync();
    chk("R5 sync in reset", phase, 0);
    wr(1'b1);
    tick(2);
    wr(1'b0);
    tick(4);
    chk("R4 restart keeps reset", int_rst_n, 0);
    wr(1'b1);
    tick(2);
    wr(1'b1);
    tick(1);
    chk("R4 lag not restarted by same value", int_rst_n, 0);
    tick(1);
    chk("R3 rise after rewrite", int_rst_n, 1);
    tick(2);
    chk("R8 flags down again", zdet_l, 0);
    chk("R9 dout passes", dout_l, din_l);
  endtask

  initial begin
    t_por();
    t_release();
    t_phase_and_ignored_sync();
    t_early_sync_and_restore();
    t_full_cycle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule